// File: doc/BRIEF.md
# UART Receive Word Packer

This block sits between a UART receiver, which hands over one finished byte per strobe, and the software that drains received data. It collects the bytes into 32-bit words, four to a word with the earliest byte in the lowest lane, and queues each completed word in a small receive FIFO. Software reaches the block through a simple word-addressed register port. That port exposes a status word, a packer-status word carrying the number of bytes still waiting in the partial word, a command register, a receive-length register and the FIFO data window.

Bytes that do not fill a word wait in the packing buffer until a flush. A flush can come from a software command, from an idle timeout (which software may turn off), or from reaching the programmed receive length. A flush pushes the partial word with zeroed upper lanes, raises a stale flag and disarms the receiver until software writes the length register again. A byte that arrives with nowhere to go sets a sticky overrun flag, which a command clears.

Top module: `uart_rx_word_packer`

## Requirements
- R1: Four accepted bytes form one FIFO word: the first byte received lands in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R2: Bit 0 of the status word (register offset 0) is 1 exactly when the FIFO holds at least one word.
- R3: The packer-status word (offset 1) reports the number of bytes in the packing buffer, 0 to 4, in bits [9:7]. All other bits read 0.
- R4: A read of the data window (offset 4) returns the oldest FIFO word and removes it. A read of an empty FIFO returns 0 and changes nothing.
- R5: A command write (offset 2) with bits [11:8] = 4 requests a flush, which takes place on the second clock edge after the write if the FIFO has room. The flush pushes the partial word with unused upper lanes zero, or pushes nothing if the buffer is empty. It then sets the byte count to 0, sets the stale flag (status bit 5) and clears the armed flag (status bit 2).
- R6: A command write with bits [7:4] = 8 clears the stale flag.
- R7: While automatic flushing is enabled (the state after reset), a buffer that holds 1 to 3 bytes and receives no byte for STALE_CYCLES clocks is flushed as in R5. A command write with bits [11:8] = 6 disables automatic flushing.
- R8: A byte that arrives while the FIFO is full and the buffer holds a complete word is dropped, and overrun (status bit 4) is set. Overrun stays set until a command write with bits [7:4] = 3. The held word enters the FIFO as soon as a word is read out.
- R9: A write to the length register (offset 3) stores the length, re-arms the receiver and restarts the accepted-byte count. When the count of bytes accepted since arming reaches a nonzero length, a flush as in R5 follows. A length of 0 means no limit. The register reads back its value, which is all ones after reset.
- R10: While disarmed, incoming bytes are discarded without changing the byte count or the overrun flag. A byte that arrives in the cycle a flush takes place is also discarded.
- R11: After reset the status word reads 0x4 (armed, FIFO empty, no flags) and the byte count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data window) |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the read strobe |

## Verification
The bench drives the block into overrun by filling the FIFO and the packing buffer, then sends one more byte. A design that queued that byte or let it overwrite the held word would return a fifth word that differs from the four bytes that completed it. Flushes are exercised on an empty buffer, on a one-byte buffer after automatic flushing has been disabled, by timeout and by reaching the length. A design that left stale bytes in the upper lanes, failed to clear the count or failed to disarm would show a wrong word or a nonzero count, or would accept the byte sent while disarmed. Reads of an empty FIFO are checked to return zero and to leave the status unchanged, which catches a pointer that moves on an empty pop.

// File: rtl/uart_rx_word_packer_pkg.sv
package uart_rx_word_packer_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int LANE_W     = $clog2(WORD_BYTES);
    localparam int CNT_W      = 3;
    localparam int ADDR_W     = 3;

    localparam logic [ADDR_W-1:0] OFS_STATUS  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_PACKSTA = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CMD     = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LENGTH  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_DATA    = 3'd4;

    localparam int ST_READY = 0;
    localparam int ST_ARMED = 2;
    localparam int ST_OVR   = 4;
    localparam int ST_STALE = 5;
    localparam int PK_LSB   = 7;

    localparam logic [3:0] LO_CLR_ERR   = 4'h3;
    localparam logic [3:0] LO_CLR_STALE = 4'h8;
    localparam logic [3:0] HI_FORCE     = 4'h4;
    localparam logic [3:0] HI_NO_AUTO   = 4'h6;

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BYTES);
endpackage

// File: rtl/uart_rx_lane_insert.sv
module uart_rx_lane_insert #(
    parameter int BYTES = 4,
    parameter int BW    = 8,
    parameter int SEL_W = 2
) (
    input  logic [BYTES*BW-1:0] base,
    input  logic                clear,
    input  logic [SEL_W-1:0]    sel,
    input  logic [BW-1:0]       din,
    output logic [BYTES*BW-1:0] dout
);
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign dout[i*BW +: BW] = (sel == SEL_W'(i)) ? din :
                                  (clear ? '0 : base[i*BW +: BW]);
    end
endmodule

// File: rtl/uart_rx_word_fifo.sv
module uart_rx_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [OW-1:0] FULLV = OW'(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_d, wr_q, rd_d, rd_q;
    logic [OW-1:0] occ_d, occ_q;
    logic          do_push, do_pop;

    assign full  = (occ_q == FULLV);
    assign empty = (occ_q == '0);
    assign head  = mem_q[rd_q];

    always_comb begin
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        wr_d  = wr_q;
        rd_d  = rd_q;
        occ_d = occ_q;
        if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + PW'(1);
        if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + PW'(1);
        if (do_push && !do_pop) occ_d = occ_q + OW'(1);
        if (do_pop && !do_push) occ_d = occ_q - OW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            occ_q <= occ_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= wdata;
    end
endmodule

// File: rtl/uart_rx_stale_timer.sv
module uart_rx_stale_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic hit
);
    localparam int TW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [TW-1:0] LIMIT = TW'(CYCLES - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign hit = run && !restart && (cnt_q == LIMIT);

    always_comb begin
        if (restart || !run || hit) cnt_d = '0;
        else                        cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_rx_word_packer.sv
module uart_rx_word_packer
    import uart_rx_word_packer_pkg::*;
#(
    parameter int FIFO_DEPTH   = 4,
    parameter int STALE_CYCLES = 16,
    parameter int LEN_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic              ovr;
        logic              stale;
        logic              armed;
        logic              auto_en;
        logic              pend;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  xfer;
    } state_t;

    state_t st_d, st_q;

    logic              fifo_push, fifo_pop, fifo_full, fifo_empty, room;
    logic [WORD_W-1:0] fifo_wdata, fifo_head, ins_word;
    logic              ins_clear;
    logic [LANE_W-1:0] ins_sel;
    logic              cmd_wr, len_wr, clr_err, flush_go, timer_hit, timer_run;
    logic              accepted, ovr_set;
    logic [LEN_W-1:0]  xfer_next;
    logic [3:0]        cmd_lo, cmd_hi;

    assign cmd_lo   = reg_wdata[7:4];
    assign cmd_hi   = reg_wdata[11:8];
    assign cmd_wr   = reg_wr && (reg_addr == OFS_CMD);
    assign len_wr   = reg_wr && (reg_addr == OFS_LENGTH);
    assign clr_err  = cmd_wr && (cmd_lo == LO_CLR_ERR);
    assign fifo_pop = reg_rd && (reg_addr == OFS_DATA) && !fifo_empty;
    assign room     = !fifo_full || fifo_pop;
    assign flush_go = st_q.pend && ((st_q.cnt == '0) || room);
    assign ins_clear = (st_q.cnt == CNT_FULL);
    assign ins_sel   = ins_clear ? '0 : st_q.cnt[LANE_W-1:0];
    assign timer_run = st_q.auto_en && st_q.armed && !st_q.pend &&
                       (st_q.cnt != '0) && (st_q.cnt != CNT_FULL);
    assign xfer_next = st_q.xfer + LEN_W'(1);

    uart_rx_lane_insert #(
        .BYTES (WORD_BYTES),
        .BW    (BYTE_W),
        .SEL_W (LANE_W)
    ) u_lane (
        .base  (st_q.word),
        .clear (ins_clear),
        .sel   (ins_sel),
        .din   (rx_byte),
        .dout  (ins_word)
    );

    uart_rx_stale_timer #(
        .CYCLES (STALE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .restart (rx_valid),
        .hit     (timer_hit)
    );

    uart_rx_word_fifo #(
        .W     (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    always_comb begin
        st_d       = st_q;
        fifo_push  = 1'b0;
        fifo_wdata = st_q.word;
        accepted   = 1'b0;
        ovr_set    = 1'b0;

        if (flush_go) begin
            fifo_push  = (st_q.cnt != '0);
            st_d.word  = '0;
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
            st_d.pend  = 1'b0;
        end else if (rx_valid && st_q.armed) begin
            if (st_q.cnt == CNT_FULL) begin
                if (room) begin
                    fifo_push = 1'b1;
                    st_d.word = ins_word;
                    st_d.cnt  = CNT_W'(1);
                    accepted  = 1'b1;
                end else begin
                    ovr_set = 1'b1;
                end
            end else if (st_q.cnt == CNT_FULL - CNT_W'(1)) begin
                accepted = 1'b1;
                if (room) begin
                    fifo_push  = 1'b1;
                    fifo_wdata = ins_word;
                    st_d.word  = '0;
                    st_d.cnt   = '0;
                end else begin
                    st_d.word = ins_word;
                    st_d.cnt  = CNT_FULL;
                end
            end else begin
                accepted  = 1'b1;
                st_d.word = ins_word;
                st_d.cnt  = st_q.cnt + CNT_W'(1);
            end
        end else if ((st_q.cnt == CNT_FULL) && room) begin
            fifo_push = 1'b1;
            st_d.word = '0;
            st_d.cnt  = '0;
        end

        if (accepted) begin
            st_d.xfer = xfer_next;
            if ((st_q.len != '0) && (xfer_next == st_q.len)) st_d.pend = 1'b1;
        end
        if (timer_hit && !flush_go) st_d.pend = 1'b1;

        if (cmd_wr) begin
            if (cmd_lo == LO_CLR_ERR)   st_d.ovr     = 1'b0;
            if (cmd_lo == LO_CLR_STALE) st_d.stale   = 1'b0;
            if (cmd_hi == HI_FORCE)     st_d.pend    = 1'b1;
            if (cmd_hi == HI_NO_AUTO)   st_d.auto_en = 1'b0;
        end
        if (ovr_set)  st_d.ovr   = 1'b1;
        if (flush_go) st_d.stale = 1'b1;

        if (len_wr) begin
            st_d.len   = reg_wdata[LEN_W-1:0];
            st_d.armed = 1'b1;
            st_d.xfer  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.armed   <= 1'b1;
            st_q.auto_en <= 1'b1;
            st_q.len     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_STATUS: begin
                reg_rdata[ST_READY] = !fifo_empty;
                reg_rdata[ST_ARMED] = st_q.armed;
                reg_rdata[ST_OVR]   = st_q.ovr;
                reg_rdata[ST_STALE] = st_q.stale;
            end
            OFS_PACKSTA: reg_rdata[PK_LSB +: CNT_W] = st_q.cnt;
            OFS_LENGTH:  reg_rdata = WORD_W'(st_q.len);
            OFS_DATA:    reg_rdata = fifo_empty ? '0 : fifo_head;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_rx_word_packer_chk.sv
module uart_rx_word_packer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       armed,
    input logic [2:0] cnt,
    input logic       ovr,
    input logic       fifo_full,
    input logic       fifo_push,
    input logic       fifo_pop,
    input logic       flush_go,
    input logic       clr_err,
    input logic       rearm
);
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 3'd4); // R3

    AST_NO_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !fifo_pop) |-> !fifo_push); // R8

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_go |=> (cnt == 3'd0)); // R5

    AST_FLUSH_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_go && !rearm) |=> !armed); // R5

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr_err) |=> ovr); // R8

    AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && armed && cnt == 3'd4 && fifo_full && !fifo_pop && !flush_go)
        |=> ovr); // R8

    AST_DISARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !rearm && !flush_go && cnt != 3'd4) |=> $stable(cnt)); // R10
endmodule

bind uart_rx_word_packer uart_rx_word_packer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .armed     (st_q.armed),
    .cnt       (st_q.cnt),
    .ovr       (st_q.ovr),
    .fifo_full (fifo_full),
    .fifo_push (fifo_push),
    .fifo_pop  (fifo_pop),
    .flush_go  (flush_go),
    .clr_err   (clr_err),
    .rearm     (len_wr)
);

// File: tb/uart_rx_word_packer_test.sv
module uart_rx_word_packer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [2:0] A_ST = 3'd0, A_PK = 3'd1, A_CMD = 3'd2, A_LEN = 3'd3, A_DAT = 3'd4;

    // stimulus bytes (first sent in the top byte) and the word they must form
    localparam logic [63:0] VECS [6] = '{
        {32'h11223344, 32'h44332211},
        {32'h00000000, 32'h00000000},
        {32'hFFFFFFFF, 32'hFFFFFFFF},
        {32'hA55A0FF0, 32'hF00F5AA5},
        {32'h01020304, 32'h04030201},
        {32'h80FE7F01, 32'h017FFE80}
    };

    always #10 clk = ~clk;

    uart_rx_word_packer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic byte_count(output logic [31:0] c);
        logic [31:0] v;
        reg_read(A_PK, v);
        c = {29'd0, v[9:7]};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R11 reset state
        reg_read(A_ST, v);  check("R11 status after reset", v, 32'h4);
        byte_count(v);      check("R11 count after reset", v, 0);
        reg_read(A_LEN, v); check("R9 length reset value", v, 32'hFFFFFFFF);
        // R4 empty read
        reg_read(A_DAT, v); check("R4 empty read returns zero", v, 0);
        reg_read(A_ST, v);  check("R4 status unchanged by empty read", v, 32'h4);

        // R1/R2/R3 vector table
        foreach (VECS[k]) begin
            for (int j = 0; j < 4; j++) begin
                send_byte(VECS[k][63 - 8*j -: 8]);
                byte_count(v);
                check("R3 byte count while packing", v, (j == 3) ? 0 : j + 1);
            end
            reg_read(A_ST, v);  check("R2 ready after full word", v, 32'h5);
            reg_read(A_DAT, v); check("R1 packed word", v, VECS[k][31:0]);
            reg_read(A_ST, v);  check("R2 ready clears after pop", v, 32'h4);
        end

        // R5 forced flush of partial word
        send_byte(8'hAB);
        send_byte(8'hCD);
        reg_write(A_CMD, 32'h400);
        idle(2);
        reg_read(A_ST, v);  check("R5 status after forced flush", v, 32'h21);
        byte_count(v);      check("R5 count zero after flush", v, 0);
        reg_read(A_DAT, v); check("R5 partial word zero upper", v, 32'h0000CDAB);
        // R10 byte while disarmed
        send_byte(8'h77);
        byte_count(v);      check("R10 disarmed byte dropped", v, 0);
        reg_read(A_ST, v);  check("R10 no overrun when disarmed", v, 32'h20);
        // R6 clear stale
        reg_write(A_CMD, 32'h80);
        reg_read(A_ST, v);  check("R6 stale cleared", v, 32'h0);
        // R9 re-arm
        reg_write(A_LEN, 32'h0);
        reg_read(A_ST, v);  check("R9 rearmed by length write", v, 32'h4);

        // R5 flush of empty buffer
        reg_write(A_CMD, 32'h400);
        idle(2);
        reg_read(A_ST, v);  check("R5 empty flush sets stale only", v, 32'h20);
        reg_write(A_CMD, 32'h80);
        reg_write(A_LEN, 32'h0);

        // R7 automatic flush by idle timeout
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        idle(40);
        reg_read(A_ST, v);  check("R7 auto flush status", v, 32'h21);
        reg_read(A_DAT, v); check("R7 auto flush word", v, 32'h00030201);
        reg_write(A_CMD, 32'h80);
        reg_write(A_LEN, 32'h0);

        // R7 auto flush disabled
        reg_write(A_CMD, 32'h600);
        send_byte(8'h5E);
        idle(40);
        byte_count(v);      check("R7 no auto flush when disabled", v, 1);
        reg_read(A_ST, v);  check("R7 status unchanged when disabled", v, 32'h4);
        reg_write(A_CMD, 32'h400);
        idle(2);
        reg_read(A_DAT, v); check("R5 forced flush single byte", v, 32'h0000005E);
        reg_write(A_CMD, 32'h80);
        reg_write(A_LEN, 32'h0);

        // R9 length limit
        reg_write(A_LEN, 32'd3);
        reg_read(A_LEN, v); check("R9 length readback", v, 32'd3);
        send_byte(8'h9A); send_byte(8'hBC); send_byte(8'hDE);
        idle(2);
        reg_read(A_ST, v);  check("R9 flush at length", v, 32'h21);
        reg_read(A_DAT, v); check("R9 word at length", v, 32'h00DEBC9A);
        reg_write(A_CMD, 32'h80);
        reg_write(A_LEN, 32'h0);

        // R8 overrun
        for (int b = 0; b < 20; b++) send_byte(8'(b + 16'h0));
        byte_count(v);      check("R3 full word held in buffer", v, 4);
        reg_read(A_ST, v);  check("R8 no overrun yet", v, 32'h5);
        send_byte(8'hEE);
        reg_read(A_ST, v);  check("R8 overrun flag set", v, 32'h15);
        byte_count(v);      check("R8 count unchanged by dropped byte", v, 4);
        reg_read(A_DAT, v); check("R8 fifo word 0", v, 32'h03020100);
        reg_read(A_DAT, v); check("R8 fifo word 1", v, 32'h07060504);
        reg_read(A_DAT, v); check("R8 fifo word 2", v, 32'h0B0A0908);
        reg_read(A_DAT, v); check("R8 fifo word 3", v, 32'h0F0E0D0C);
        reg_read(A_DAT, v); check("R8 held word enters fifo", v, 32'h13121110);
        reg_read(A_ST, v);  check("R8 overrun sticky", v, 32'h14);
        reg_write(A_CMD, 32'h30);
        reg_read(A_ST, v);  check("R8 overrun cleared", v, 32'h4);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule